// File: doc/BRIEF.md
# Fragmenting Slot Mailbox Transmitter

This block sends a byte message into a mailbox made of 32-bit slots. Each request supplies a length, a host address and a client address. The block reads the payload from a byte-addressed source and writes it as one or more fragments. A fragment is one header slot followed by the payload slots. The fragment size depends on the mailbox depth the peer advertises when the attempt starts. The peer is the consumer on the other side of the mailbox.

Before each header, the block waits for free space. It waits again before each body. When a fragment is complete it pulses an interrupt request to the peer. If the peer is no longer ready, or a wait lasts too long, the whole message is started again from its first byte. The number of attempts is limited. A one-cycle done pulse reports the result together with a pass/fail flag.

Top module: `frag_tx`

## Requirements
- R1: A header slot holds the complete flag in bit 31, the fragment byte length in bits 24:16, the host address in bits 15:8 and the client address in bits 7:0. Bits 30:25 are zero.
- R2: The largest fragment payload is min(4·depth, 511) − 4 bytes, where depth is sampled when the peer becomes ready. A depth below 2 fails the attempt without writing any slot.
- R3: Only the fragment that carries the final bytes of the message has the complete flag set.
- R4: A header is written only while at least one slot is empty. The body is written only after at least ceil(length/4) slots are empty.
- R5: Payload bytes are packed little-endian: the byte at the lowest offset goes in bits 7:0. In a trailing partial word, the unused upper bytes are zero.
- R6: `irq_gen` is high for exactly one cycle, in the cycle after the last slot of each fragment. If `peer_ready` is low in that cycle, the attempt fails.
- R7: A message is attempted at most RETRIES times (default 5). Each attempt first waits for `peer_ready`, then restarts from byte offset 0.
- R8: A request with zero length, or with `req_null` set, produces `done` with `pass` low in the next cycle and writes no slot.
- R9: A wait for peer ready, header space or body space that lasts WAIT_CYC cycles fails the attempt.
- R10: `done` is a one-cycle pulse, and `pass` is valid while `done` is high. Both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| req_null | input | 1 | Request has no payload source |
| msg_len | input | LEN_W | Message length in bytes |
| host_addr | input | 8 | Host address placed in each header |
| client_addr | input | 8 | Client address placed in each header |
| rd_addr | output | LEN_W | Byte offset of the payload word being read |
| rd_word | input | 32 | Four payload bytes starting at rd_addr, little-endian |
| peer_ready | input | 1 | Peer ready flag |
| slot_depth | input | 8 | Mailbox depth in slots |
| slot_empty | input | 8 | Number of empty mailbox slots |
| slot_wr | output | 1 | Slot write strobe |
| slot_data | output | 32 | Slot write data |
| irq_gen | output | 1 | Interrupt request to the peer, one cycle per fragment |
| done | output | 1 | Request finished |
| pass | output | 1 | Result: 1 means the message was sent |

## Verification
The hardest case to reach from the ports is a retry in the middle of a message. The peer has to drop ready in exactly the cycle after a fragment's last slot, after one fragment has already been written. The bench's mailbox model watches the slot-write count and lowers `peer_ready` on the write that ends the first fragment. It raises it again a few cycles later. The bench then expects the partial first transfer followed by a complete resend that starts at offset 0.

Body-space waiting is reached in a similar way. The mailbox is pre-filled so that only the header fits. The bench confirms that exactly one slot was written before it frees the space.

// File: rtl/frag_tx_pkg.sv
package frag_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_HWAIT,
    ST_HDR,
    ST_BWAIT,
    ST_BODY,
    ST_IRQ,
    ST_DONE
  } tx_state_e;

  localparam int FLEN_W   = 9;
  localparam int FLEN_CAP = 511;
endpackage

// File: rtl/frag_tx_timer.sv
module frag_tx_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && !expired)
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= CW'(LIMIT - 1));
endmodule

// File: rtl/frag_tx_plan.sv
module frag_tx_plan #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] offset,
  input  logic [8:0]       max_pay,
  input  logic [7:0]       host,
  input  logic [7:0]       client,
  output logic [8:0]       flen,
  output logic [7:0]       nslots,
  output logic             last,
  output logic [31:0]      header
);
  logic [LEN_W-1:0] remaining;
  logic [9:0]       rounded;

  assign remaining = len - offset;
  assign last      = (remaining <= LEN_W'(max_pay));
  assign flen      = last ? remaining[8:0] : max_pay;
  assign rounded   = {1'b0, flen} + 10'd3;
  assign nslots    = rounded[9:2];
  assign header    = {last, 6'b0, flen, host, client};
endmodule

// File: rtl/frag_tx_pad.sv
module frag_tx_pad (
  input  logic [31:0] word_in,
  input  logic [2:0]  keep,
  output logic [31:0] word_out
);
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign word_out[8*b +: 8] = (3'(b) < keep) ? word_in[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/frag_tx.sv
module frag_tx
  import frag_tx_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int RETRIES  = 5,
  parameter int WAIT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_null,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [7:0]       host_addr,
  input  logic [7:0]       client_addr,
  output logic [LEN_W-1:0] rd_addr,
  input  logic [31:0]      rd_word,
  input  logic             peer_ready,
  input  logic [7:0]       slot_depth,
  input  logic [7:0]       slot_empty,
  output logic             slot_wr,
  output logic [31:0]      slot_data,
  output logic             irq_gen,
  output logic             done,
  output logic             pass
);
  localparam int TRY_W = $clog2(RETRIES + 1);

  tx_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] off_q, off_d;
  logic [7:0]       host_q, host_d, client_q, client_d;
  logic [8:0]       maxp_q, maxp_d;
  logic [7:0]       widx_q, widx_d;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic             pass_q, pass_d;

  logic [8:0]  flen;
  logic [7:0]  nslots;
  logic        last;
  logic [31:0] header, body_word;
  logic [9:0]  cb_bytes, cb_cap, rem_bytes;
  logic [2:0]  keep;
  logic        attempt_fail, waiting, expired, tmr_clr;

  frag_tx_plan #(.LEN_W(LEN_W)) u_plan (
    .len(len_q), .offset(off_q), .max_pay(maxp_q), .host(host_q),
    .client(client_q), .flen(flen), .nslots(nslots), .last(last),
    .header(header)
  );

  assign rem_bytes = {1'b0, flen} - {widx_q, 2'b00};
  assign keep      = (rem_bytes >= 10'd4) ? 3'd4 : rem_bytes[2:0];

  frag_tx_pad u_pad (.word_in(rd_word), .keep(keep), .word_out(body_word));

  assign waiting = (state_q == ST_READY) || (state_q == ST_HWAIT) ||
                   (state_q == ST_BWAIT);
  assign tmr_clr = (state_d != state_q) || attempt_fail;

  frag_tx_timer #(.LIMIT(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(waiting), .expired(expired)
  );

  assign cb_bytes = {slot_depth, 2'b00};
  assign cb_cap   = (cb_bytes > 10'(FLEN_CAP)) ? 10'(FLEN_CAP) : cb_bytes;

  always_comb begin
    state_d      = state_q;
    len_d        = len_q;
    off_d        = off_q;
    host_d       = host_q;
    client_d     = client_q;
    maxp_d       = maxp_q;
    widx_d       = widx_q;
    tries_d      = tries_q;
    pass_d       = pass_q;
    attempt_fail = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (req_null || (msg_len == '0)) begin
          pass_d  = 1'b0;
          state_d = ST_DONE;
        end else begin
          len_d    = msg_len;
          host_d   = host_addr;
          client_d = client_addr;
          tries_d  = '0;
          state_d  = ST_READY;
        end
      end
      ST_READY: if (peer_ready) begin
        if (slot_depth < 8'd2) begin
          attempt_fail = 1'b1;
        end else begin
          maxp_d  = 9'(cb_cap - 10'd4);
          off_d   = '0;
          state_d = ST_HWAIT;
        end
      end else if (expired) begin
        attempt_fail = 1'b1;
      end
      ST_HWAIT: begin
        if (slot_empty != 8'd0) state_d = ST_HDR;
        else if (expired)       attempt_fail = 1'b1;
      end
      ST_HDR: begin
        widx_d  = '0;
        state_d = ST_BWAIT;
      end
      ST_BWAIT: begin
        if (slot_empty >= nslots) state_d = ST_BODY;
        else if (expired)         attempt_fail = 1'b1;
      end
      ST_BODY: begin
        if (widx_q == nslots - 8'd1) state_d = ST_IRQ;
        else                         widx_d  = widx_q + 8'd1;
      end
      ST_IRQ: begin
        if (!peer_ready) begin
          attempt_fail = 1'b1;
        end else if (last) begin
          pass_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          off_d   = off_q + LEN_W'(flen);
          state_d = ST_HWAIT;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (attempt_fail) begin
      if (tries_q == TRY_W'(RETRIES - 1)) begin
        pass_d  = 1'b0;
        state_d = ST_DONE;
      end else begin
        tries_d = tries_q + TRY_W'(1);
        state_d = ST_READY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      off_q    <= '0;
      host_q   <= '0;
      client_q <= '0;
      maxp_q   <= '0;
      widx_q   <= '0;
      tries_q  <= '0;
      pass_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      len_q    <= len_d;
      off_q    <= off_d;
      host_q   <= host_d;
      client_q <= client_d;
      maxp_q   <= maxp_d;
      widx_q   <= widx_d;
      tries_q  <= tries_d;
      pass_q   <= pass_d;
    end
  end

  assign rd_addr   = off_q + LEN_W'({widx_q, 2'b00});
  assign slot_wr   = (state_q == ST_HDR) || (state_q == ST_BODY);
  assign slot_data = (state_q == ST_HDR) ? header :
                     (state_q == ST_BODY) ? body_word : 32'h0;
  assign irq_gen   = (state_q == ST_IRQ);
  assign done      = (state_q == ST_DONE);
  assign pass      = done && pass_q;
endmodule

// File: rtl/frag_tx_chk.sv
module frag_tx_chk
  import frag_tx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] msg_len,
  input logic             slot_wr,
  input logic [31:0]      slot_data,
  input logic [7:0]       slot_empty,
  input logic             irq_gen,
  input logic             done,
  input logic             pass,
  input tx_state_e        st
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_irq_follows_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gen |-> ($past(slot_wr) && !slot_wr));

  a_r4_hdr_space: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> ($past(slot_empty) != 8'd0));

  a_r2_hdr_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> ((slot_data[24:16] != 9'd0) &&
                        (slot_data[24:16] <= 9'd507) &&
                        (slot_data[30:25] == 6'd0)));

  a_r8_reject_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && start && (msg_len == '0)) |=> (done && !pass));
endmodule

bind frag_tx frag_tx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
  .slot_wr(slot_wr), .slot_data(slot_data), .slot_empty(slot_empty),
  .irq_gen(irq_gen), .done(done), .pass(pass), .st(state_q)
);

// File: tb/frag_tx_test.sv
module frag_tx_test;
  localparam int LEN_W = 16;
  localparam int WAITC = 50;

  logic             clk, rst_n, start, req_null, peer_ready, slot_wr;
  logic             irq_gen, done, pass;
  logic [LEN_W-1:0] msg_len, rd_addr;
  logic [7:0]       host_addr, client_addr, slot_depth, slot_empty;
  logic [31:0]      rd_word, slot_data;

  frag_tx #(.LEN_W(LEN_W), .RETRIES(5), .WAIT_CYC(WAITC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_null(req_null),
    .msg_len(msg_len), .host_addr(host_addr), .client_addr(client_addr),
    .rd_addr(rd_addr), .rd_word(rd_word), .peer_ready(peer_ready),
    .slot_depth(slot_depth), .slot_empty(slot_empty), .slot_wr(slot_wr),
    .slot_data(slot_data), .irq_gen(irq_gen), .done(done), .pass(pass)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0]  mem [0:1023];
  logic [31:0] log_w [0:1023];
  logic [31:0] exp_w [0:1023];
  int nlog, nirq, fill, prefill, depth, drop_at, drop_cnt, base, nexp;
  bit auto_drain, drain_req, peer_en;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign rd_word = {mem[10'(rd_addr + 16'd3)], mem[10'(rd_addr + 16'd2)],
                    mem[10'(rd_addr + 16'd1)], mem[10'(rd_addr)]};
  assign peer_ready = peer_en && (drop_cnt == 0);

  always_comb begin
    int e;
    e = depth - fill - prefill;
    slot_empty = (e < 0) ? 8'd0 : 8'(e);
    slot_depth = 8'(depth);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nlog <= 0; nirq <= 0; fill <= 0; drop_cnt <= 0;
    end else begin
      if (slot_wr) begin
        log_w[nlog] <= slot_data;
        nlog <= nlog + 1;
      end
      if (irq_gen) nirq <= nirq + 1;
      if (drain_req || (auto_drain && irq_gen)) fill <= 0;
      else if (slot_wr) fill <= fill + 1;
      if (slot_wr && (nlog == drop_at)) drop_cnt <= 6;
      else if (drop_cnt != 0) drop_cnt <= drop_cnt - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks = checks + 1;
    if (act !== expv) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic void build(int len, int dep, logic [7:0] h, logic [7:0] c);
    int maxp, off, fl, k;
    logic [31:0] w;
    maxp = ((dep * 4 > 511) ? 511 : dep * 4) - 4;
    off = 0; k = 0;
    while (off < len) begin
      fl = (len - off < maxp) ? len - off : maxp;
      exp_w[k] = {(fl == len - off), 6'b0, 9'(fl), h, c};
      k++;
      for (int wi = 0; wi < (fl + 3) / 4; wi++) begin
        w = 32'h0;
        for (int b = 0; b < 4; b++)
          if (wi * 4 + b < fl) w[8*b +: 8] = mem[(off + wi * 4 + b) % 1024];
        exp_w[k] = w;
        k++;
      end
      off += fl;
    end
    nexp = k;
  endfunction

  task automatic kick(int len, logic [7:0] h, logic [7:0] c, bit nul);
    @(negedge clk);
    base = nlog;
    msg_len = 16'(len); host_addr = h; client_addr = c; req_null = nul;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; req_null = 1'b0;
  endtask

  task automatic wait_done(output bit ok, output int n);
    n = 1;
    ok = done;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    ok = pass;
  endtask

  task automatic cmp_stream(string req, int from);
    chk(req, 32'(nlog - from), 32'(nexp));
    for (int i = 0; i < nexp && from + i < nlog; i++)
      chk(req, log_w[from + i], exp_w[i]);
  endtask

  task automatic t_reset;
    chk("R10 reset done", {31'b0, done}, 0);
    chk("R10 reset slot_wr", {31'b0, slot_wr}, 0);
    chk("R10 reset irq", {31'b0, irq_gen}, 0);
  endtask

  task automatic t_single;
    bit ok; int n, i0;
    depth = 32; i0 = nirq;
    kick(10, 8'h12, 8'h34, 0);
    wait_done(ok, n);
    chk("R10 single pass", {31'b0, ok}, 1);
    build(10, 32, 8'h12, 8'h34);
    chk("R1 header word", log_w[base], 32'h800A1234);
    cmp_stream("R5 packed stream", base);
    @(negedge clk);
    chk("R6 one irq per fragment", 32'(nirq - i0), 1);
    chk("R10 done pulse", {31'b0, done}, 0);
  endtask

  task automatic t_frag;
    bit ok; int n, i0;
    depth = 8; i0 = nirq;
    kick(60, 8'hA5, 8'h07, 0);
    wait_done(ok, n);
    chk("R3 frag pass", {31'b0, ok}, 1);
    build(60, 8, 8'hA5, 8'h07);
    chk("R3 first header not complete", log_w[base], 32'h001CA507);
    chk("R3 last header complete", log_w[base + 16], 32'h8004A507);
    cmp_stream("R2 fragments depth 8", base);
    @(negedge clk);
    chk("R6 irq count", 32'(nirq - i0), 3);
  endtask

  task automatic t_big;
    bit ok; int n;
    depth = 200;
    kick(600, 8'h01, 8'hFE, 0);
    wait_done(ok, n);
    chk("R2 cap pass", {31'b0, ok}, 1);
    build(600, 200, 8'h01, 8'hFE);
    chk("R2 511 cap header", log_w[base], 32'h01FB01FE);
    cmp_stream("R2 unaligned second fragment", base);
  endtask

  task automatic t_reject;
    bit ok; int n;
    depth = 32;
    kick(0, 8'h00, 8'h00, 0);
    wait_done(ok, n);
    chk("R8 zero len fail", {31'b0, ok}, 0);
    chk("R8 zero len latency", 32'(n), 1);
    kick(5, 8'h00, 8'h00, 1);
    wait_done(ok, n);
    chk("R8 null fail", {31'b0, ok}, 0);
    chk("R8 no writes", 32'(nlog - base), 0);
  endtask

  task automatic t_body_wait;
    bit ok; int n;
    depth = 8; prefill = 6;
    kick(20, 8'h22, 8'h33, 0);
    repeat (20) @(negedge clk);
    chk("R4 only header before space", 32'(nlog - base), 1);
    prefill = 0; drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
    wait_done(ok, n);
    chk("R4 body after space pass", {31'b0, ok}, 1);
    build(20, 8, 8'h22, 8'h33);
    cmp_stream("R4 stream", base);
  endtask

  task automatic t_ready_drop;
    bit ok; int n;
    depth = 8;
    drop_at = nlog + 7;
    kick(60, 8'h44, 8'h55, 0);
    wait_done(ok, n);
    drop_at = -1;
    chk("R7 retry pass", {31'b0, ok}, 1);
    build(60, 8, 8'h44, 8'h55);
    chk("R6 partial then resend count", 32'(nlog - base), 32'(8 + nexp));
    cmp_stream("R7 resend from offset 0", base + 8);
  endtask

  task automatic t_timeouts;
    bit ok; int n;
    depth = 8; prefill = 8;
    kick(12, 8'h66, 8'h77, 0);
    wait_done(ok, n);
    chk("R9 header wait timeout fail", {31'b0, ok}, 0);
    chk("R9 no writes", 32'(nlog - base), 0);
    chk("R7 five attempts span", 32'(n >= 5 * WAITC && n < 6 * WAITC), 1);
    prefill = 0; peer_en = 1'b0;
    kick(12, 8'h66, 8'h77, 0);
    wait_done(ok, n);
    chk("R9 ready timeout fail", {31'b0, ok}, 0);
    peer_en = 1'b1; depth = 1;
    kick(12, 8'h66, 8'h77, 0);
    wait_done(ok, n);
    chk("R2 depth 1 fail", {31'b0, ok}, 0);
    chk("R2 depth 1 no writes", 32'(nlog - base), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + 5);
    rst_n = 1'b0; start = 1'b0; req_null = 1'b0; msg_len = '0;
    host_addr = '0; client_addr = '0; peer_en = 1'b1; depth = 32;
    prefill = 0; drop_at = -1; auto_drain = 1'b1; drain_req = 1'b0; base = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_frag;
    t_big;
    t_reject;
    t_body_wait;
    t_ready_drop;
    t_timeouts;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule